// File: doc/BRIEF.md
# Timecode Transmit Bit-Clock Divider and Biphase-Mark Encoder

This block builds the transmit side of a longitudinal timecode generator. A reference time base, normally 96 kHz, enters as a one-cycle strobe `ref_tick` in the system clock domain. A rate divider counts these strobes and emits a short pulse at twice the wanted bit rate. Four select codes cover the digital-audio, SMPTE, EBU and film rates. A toggle stage turns that pulse stream into a square bit clock with exactly 50% duty. An encoder then converts NRZ bits into a biphase-mark line signal. The output changes level at every cell boundary, which is the rising bit-clock edge. It changes level again at mid-cell, the falling edge, when the bit is a one.

The NRZ bits arrive over a valid/ready stream. `bit_ready` is a single-cycle pulse in the cycle that ends with a cell boundary. The bit presented in that cycle is taken when `bit_valid` is high. A source may hold `bit_valid` high and change `bit_data` after each accepted transfer, which gives the same timing as changing data on the bit clock's rising edge. The block cannot stall. If no bit is offered at a boundary, a zero goes out. Only the source is ever held back, and it is held back by `bit_ready` staying low between boundaries.

Top module: `tc_fm_gen`

## Requirements
- R1: `rate_sel` selects the number of reference ticks per divider pulse: 2'b00 gives 1, 2'b01 gives 20, 2'b10 gives 24 and 2'b11 gives 25.
- R2: `half_pulse` is high for one clock cycle per divider period, in the cycle after the clock edge that samples the completing `ref_tick`; the first tick after reset completes a period. For ratio 1 with a tick on every cycle it stays high.
- R3: Only cycles with `ref_tick` high advance the divider. If a tick arrives every G cycles, the pulses come G times the ratio apart.
- R4: A change of `rate_sel` takes effect only at the next reload, so the period already running finishes with the old ratio.
- R5: `bit_clk` toggles on the clock edge after each `half_pulse` cycle, so its high time and its low time each equal one divider period.
- R6: `bit_ready` is high exactly in cycles where `half_pulse` is high and `bit_clk` is low, that is, the cycle before a rising bit-clock edge.
- R7: `fm_out` inverts on every rising edge of `bit_clk`, on the same clock edge.
- R8: On a falling edge of `bit_clk`, `fm_out` inverts if and only if the bit taken at the preceding rise was 1.
- R9: A cell whose boundary sees `bit_valid` low is encoded as a 0.
- R10: While `rst_n` is low, `fm_out`, `bit_clk`, `half_pulse` and `bit_ready` are low and the divider is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle strobe per reference period |
| rate_sel | input | 2 | Divide-ratio select code |
| bit_valid | input | 1 | NRZ bit offered |
| bit_data | input | 1 | NRZ bit value |
| bit_ready | output | 1 | Bit taken at this cycle's closing edge |
| half_pulse | output | 1 | Divider pulse at twice the bit rate |
| bit_clk | output | 1 | 50% duty transmit bit clock |
| fm_out | output | 1 | Biphase-mark encoded timecode |

## Verification
The assertions assume that `ref_tick` is a synchronous strobe that is never sampled during reset. They also assume that `rate_sel` holds a legal two-bit code. Every code is legal, so any value of `rate_sel` is allowed. The bench drives all inputs on the falling clock edge and generates ticks from a fixed gap counter, which keeps every tick exactly one clock wide. It changes `rate_sel` only directly after a visible pulse, so the expected period of the next reload does not depend on where the change lands.

// File: rtl/tcgen_pkg.sv
package tcgen_pkg;
  typedef enum logic [1:0] {
    RATE_AUDIO = 2'b00,
    RATE_SMPTE = 2'b01,
    RATE_EBU   = 2'b10,
    RATE_FILM  = 2'b11
  } rate_e;

  function automatic int unsigned max4(input int unsigned a, input int unsigned b,
                                       input int unsigned c, input int unsigned d);
    int unsigned m;
    m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    if (d > m) m = d;
    return m;
  endfunction
endpackage

// File: rtl/rate_divider.sv
module rate_divider
  import tcgen_pkg::*;
#(
  parameter int unsigned DIV_AUDIO = 1,
  parameter int unsigned DIV_SMPTE = 20,
  parameter int unsigned DIV_EBU   = 24,
  parameter int unsigned DIV_FILM  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [1:0] rate_sel,
  output logic       pulse
);
  localparam int unsigned MAXDIV = max4(DIV_AUDIO, DIV_SMPTE, DIV_EBU, DIV_FILM);
  localparam int unsigned CW     = (MAXDIV > 1) ? $clog2(MAXDIV) : 1;

  logic [CW-1:0] remain_q;
  logic [CW-1:0] reload_val;
  logic [CW-1:0] active_max_q;

  always_comb begin
    unique case (rate_e'(rate_sel))
      RATE_AUDIO: reload_val = CW'(DIV_AUDIO - 1);
      RATE_SMPTE: reload_val = CW'(DIV_SMPTE - 1);
      RATE_EBU:   reload_val = CW'(DIV_EBU - 1);
      default:    reload_val = CW'(DIV_FILM - 1);
    endcase
  end

  // Reload at terminal count; the select is only looked at here (R4).
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q     <= '0;
      active_max_q <= '0;
      pulse        <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (ref_tick) begin
        if (remain_q == '0) begin
          remain_q     <= reload_val;
          active_max_q <= reload_val;
          pulse        <= 1'b1;
        end else begin
          remain_q <= remain_q - 1'b1;
        end
      end
    end
  end

  assert_pulse_from_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(ref_tick));
  assert_no_early_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_tick && remain_q != '0) |=> !pulse);
  assert_count_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    remain_q <= active_max_q);
  assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !ref_tick |=> $stable(remain_q));
endmodule

// File: rtl/clk_squarer.sv
module clk_squarer (
  input  logic clk,
  input  logic rst_n,
  input  logic pulse,
  output logic sq_clk,
  output logic rise_stb,
  output logic fall_stb
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sq_clk <= 1'b0;
    else if (pulse) sq_clk <= ~sq_clk;
  end

  assign rise_stb = pulse & ~sq_clk;
  assign fall_stb = pulse & sq_clk;

  assert_toggle_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> (sq_clk != $past(sq_clk)));
  assert_hold_without_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !pulse |=> $stable(sq_clk));
  assert_strobes_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rise_stb, fall_stb}));
endmodule

// File: rtl/fm_encoder.sv
module fm_encoder (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_stb,
  input  logic fall_stb,
  input  logic in_valid,
  input  logic in_data,
  output logic in_ready,
  output logic line_out
);
  logic cell_bit_q;

  assign in_ready = rise_stb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cell_bit_q <= 1'b0;
      line_out   <= 1'b0;
    end else if (rise_stb) begin
      cell_bit_q <= in_valid & in_data;   // underrun sends a zero (R9)
      line_out   <= ~line_out;
    end else if (fall_stb && cell_bit_q) begin
      line_out <= ~line_out;
    end
  end

  assert_boundary_flip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rise_stb |=> (line_out != $past(line_out)));
  assert_quiet_between_edges_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rise_stb || fall_stb) |=> $stable(line_out));
  assert_zero_on_underrun_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_stb && !in_valid) |=> !cell_bit_q);
endmodule

// File: rtl/tc_fm_gen.sv
module tc_fm_gen
  import tcgen_pkg::*;
#(
  parameter int unsigned DIV_AUDIO = 1,
  parameter int unsigned DIV_SMPTE = 20,
  parameter int unsigned DIV_EBU   = 24,
  parameter int unsigned DIV_FILM  = 25
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic [1:0] rate_sel,
  input  logic       bit_valid,
  input  logic       bit_data,
  output logic       bit_ready,
  output logic       half_pulse,
  output logic       bit_clk,
  output logic       fm_out
);
  logic rise_stb, fall_stb;

  rate_divider #(
    .DIV_AUDIO(DIV_AUDIO), .DIV_SMPTE(DIV_SMPTE),
    .DIV_EBU(DIV_EBU),     .DIV_FILM(DIV_FILM)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .rate_sel(rate_sel), .pulse(half_pulse)
  );

  clk_squarer u_sq (
    .clk(clk), .rst_n(rst_n), .pulse(half_pulse),
    .sq_clk(bit_clk), .rise_stb(rise_stb), .fall_stb(fall_stb)
  );

  fm_encoder u_enc (
    .clk(clk), .rst_n(rst_n), .rise_stb(rise_stb), .fall_stb(fall_stb),
    .in_valid(bit_valid), .in_data(bit_data),
    .in_ready(bit_ready), .line_out(fm_out)
  );

  assert_ready_at_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    bit_ready |=> $rose(bit_clk));
endmodule

// File: tb/test_tc_fm_gen.sv
module test_tc_fm_gen;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ref_tick = 1'b0;
  logic [1:0] rate_sel = 2'b00;
  logic bit_valid = 1'b0;
  logic bit_data = 1'b0;
  logic bit_ready, half_pulse, bit_clk, fm_out;

  int n_run = 0;
  int n_fail = 0;
  int gap = 1;
  int phase = 0;

  always #4 clk = ~clk;

  tc_fm_gen i_tc_fm_gen (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .rate_sel(rate_sel),
    .bit_valid(bit_valid), .bit_data(bit_data), .bit_ready(bit_ready),
    .half_pulse(half_pulse), .bit_clk(bit_clk), .fm_out(fm_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Advance one clock: drive the tick for this cycle, return at the next falling edge.
  task automatic step();
    ref_tick = (phase == 0);
    phase = (phase + 1) % gap;
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; ref_tick = 1'b0; bit_valid = 1'b0; phase = 0;
    @(negedge clk);
    check({fm_out, bit_clk, half_pulse, bit_ready} == 4'b0, "R10",
          {fm_out, bit_clk, half_pulse, bit_ready}, 0);
    rst_n = 1'b1;
  endtask

  task automatic wait_pulse();
    for (int i = 0; i < 5000; i++) begin
      if (half_pulse) return;
      step();
    end
  endtask

  task automatic measure(output int n);
    n = 0;
    for (int i = 0; i < 5000; i++) begin
      step(); n++;
      if (half_pulse) return;
    end
  endtask

  task automatic t_period(input logic [1:0] sel, input int g, input int exp, input string req);
    int n;
    gap = g; rate_sel = sel;
    do_reset();
    step();
    check(half_pulse == 1'b1, "R2", half_pulse, 1);  // first tick completes a period
    measure(n);
    check(n == exp, req, n, exp);
    if (exp > 1) begin
      step();
      check(half_pulse == 1'b0, "R2", half_pulse, 0);
    end
  endtask

  task automatic t_rate_change();
    int n;
    gap = 1; rate_sel = 2'b01;
    do_reset();
    wait_pulse();
    rate_sel = 2'b11;
    measure(n);
    check(n == 20, "R4", n, 20);
    measure(n);
    check(n == 25, "R4", n, 25);
  endtask

  task automatic t_duty();
    int hi, lo;
    gap = 1; rate_sel = 2'b01;
    do_reset();
    for (int i = 0; i < 200 && !bit_clk; i++) step();
    hi = 0;
    for (int i = 0; i < 200 && bit_clk; i++) begin step(); hi++; end
    lo = 0;
    for (int i = 0; i < 200 && !bit_clk; i++) begin step(); lo++; end
    check(hi == 20, "R5", hi, 20);
    check(lo == 20, "R5", lo, 20);
  endtask

  // Send bits; valid=0 entries model an underrun.
  task automatic t_encode(input logic [1:0] sel, input int g, input logic [7:0] bits,
                          input logic [7:0] vld, input string req);
    logic prev;
    logic eff;
    gap = g; rate_sel = sel;
    do_reset();
    for (int k = 0; k < 8; k++) begin
      for (int i = 0; i < 5000 && !bit_ready; i++) begin
        step();
        if (bit_ready) check(half_pulse && !bit_clk, "R6", {half_pulse, bit_clk}, 2);
      end
      bit_valid = vld[k]; bit_data = bits[k];
      eff = vld[k] & bits[k];
      prev = fm_out;
      step();
      check(bit_clk == 1'b1 && fm_out != prev, "R7", fm_out, !prev);
      bit_valid = 1'b0; bit_data = 1'b0;
      prev = fm_out;
      for (int i = 0; i < 5000 && bit_clk; i++) begin
        if (bit_ready) check(1'b0, "R6", bit_ready, 0);
        step();
      end
      check((fm_out != prev) == eff, req, fm_out, eff ? !prev : prev);
    end
  endtask

  task automatic t_reset_mid();
    gap = 1; rate_sel = 2'b00; bit_valid = 1'b1; bit_data = 1'b1;
    for (int i = 0; i < 5; i++) step();
    rst_n = 1'b0;
    #1;
    check({fm_out, bit_clk, half_pulse, bit_ready} == 4'b0, "R10",
          {fm_out, bit_clk, half_pulse, bit_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1; bit_valid = 1'b0;
  endtask

  initial begin
    #1600000;
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    t_period(2'b00, 1, 1, "R1");
    t_period(2'b01, 1, 20, "R1");
    t_period(2'b10, 1, 24, "R1");
    t_period(2'b11, 1, 25, "R1");
    t_period(2'b10, 3, 72, "R3");
    t_period(2'b00, 4, 4, "R3");
    t_rate_change();
    t_duty();
    t_encode(2'b00, 1, 8'b1011_0010, 8'hFF, "R8");
    t_encode(2'b01, 2, 8'b0110_1101, 8'hFF, "R8");
    t_encode(2'b00, 1, 8'b1111_1111, 8'b1010_0101, "R9");
    t_reset_mid();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule